// File: doc/BRIEF.md
# Stable-Matching Crossbar Scheduler

This block computes one conflict-free pairing of inputs to outputs for a small crossbar in each scheduling phase. Two scheduling phases fit in each cell time, which gives the fabric a speedup of two. For every input it receives a ranked list of waiting cells, with slot 0 at the head. Each cell carries the output it is bound for, a departure rank for that output, and an active flag. The ranks, the active flags and the queue storage are produced elsewhere.

On a start pulse the block captures the lists. It then runs one iteration per clock. Each iteration looks for a sink: an active, still-eligible cell that has no eligible cell ahead of it in its own input list and none ahead of it in its output's departure order. The block matches the sink. It then drops every cell that shares the sink's input or output. The run stops as soon as nothing is eligible or no sink exists. At that point the per-input grants hold the result and a one-cycle done pulse marks it. A phase output tells the first scheduling phase of a cell time apart from the second.

Top module: `stable_match_sched`

## Requirements
- R1: In one result, no two valid grants name the same output, and each input has at most one grant.
- R2: After a run that ends with no eligible cell left, every active cell (i,k) satisfies one of three conditions: it is granted; input i is granted a slot below k; or its output is granted a cell that is ahead of it in that output's order.
- R3: Only cells whose cellActive bit is 1 are granted. An inactive cell never blocks a cell behind it in its list.
- R4: When several sinks exist at once, the sink on the lowest input index is matched first. The final grants equal the result of repeating this sink selection until the run ends.
- R5: A cell that is first in its input list and first in its output's order is always granted.
- R6: busy is 1 for the cycles of a run, one cycle per iteration. done is a single-cycle pulse that comes at most NPORT cycles after the start edge.
- R7: A start with no active cell ends after one cycle with every grantValid bit at 0.
- R8: Output order compares ranks, and the lower rank departs earlier. Equal ranks are ordered by lower input index, then by lower slot.
- R9: The inputs are sampled only in the cycle in which start is taken. Changes to the inputs during a run, and start pulses during a run, have no effect.
- R10: All grants clear when a start is taken. After done, grants hold until the next start.
- R11: runPhase is 0 for the first run after reset and flips on each start that is taken: 0 marks the first scheduling phase, 1 the second.
- R12: After reset, busy, done, runPhase and every grantValid bit are 0.
- R13: If eligible cells remain but none of them is a sink, the run ends in the next cycle and those cells stay unmatched.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a scheduling phase; ignored while busy |
| cellDest | input | NPORT*DEPTH*log2(NPORT) | Output index of slot k of input i, at [i][k] |
| cellRank | input | NPORT*DEPTH*RANKW | Departure rank of slot k of input i; lower departs earlier |
| cellActive | input | NPORT*DEPTH | Slot takes part in matching when 1 |
| grantValid | output | NPORT | Input i holds a grant |
| grantOut | output | NPORT*log2(NPORT) | Granted output for input i |
| grantSlot | output | NPORT*log2(DEPTH) | Granted list slot for input i |
| busy | output | 1 | A run is in progress |
| done | output | 1 | One-cycle pulse when the result is final |
| runPhase | output | 1 | Which scheduling phase of the cell time the run belongs to |

## Verification
The hardest cases to reach are a dependency cycle with no sink at all, and several sinks that are ready at once so that the tie-break decides the order. The bench builds crafted lists to reach both: two inputs whose heads block each other across two outputs, and inputs that tie on rank for one output. Pseudo-random lists with colliding ranks then reach mixed cases. Each result is compared with a reference sink search and, when the run ends with no eligible cell left, with the stability conditions.

// File: rtl/xbar_sched_pkg.sv
package xbar_sched_pkg;
  localparam int NPORT_DEF = 4;
  localparam int DEPTH_DEF = 4;
  localparam int RANKW_DEF = 6;

  typedef struct packed {
    logic load;
    logic step;
  } schedStrobe_t;
endpackage

// File: rtl/sm_ctrl.sv
module sm_ctrl
  import xbar_sched_pkg::*;
#(
  parameter int NPORT = NPORT_DEF
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         start,
  input  logic         sinkFound,
  input  logic         lastStep,
  output schedStrobe_t stb,
  output logic         busy,
  output logic         done,
  output logic         runPhase
);
  localparam int IW = $clog2(NPORT + 1);

  logic          busyQ;
  logic          doneQ;
  logic          phaseQ;
  logic          nextPhase;
  logic [IW-1:0] iterCnt;
  logic          finish;

  always_comb begin
    stb.load = start & ~busyQ;
    stb.step = busyQ;
    finish   = busyQ & (~sinkFound | lastStep);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busyQ     <= 1'b0;
      doneQ     <= 1'b0;
      phaseQ    <= 1'b0;
      nextPhase <= 1'b0;
      iterCnt   <= '0;
    end else begin
      doneQ <= finish;
      if (stb.load) begin
        busyQ     <= 1'b1;
        iterCnt   <= '0;
        phaseQ    <= nextPhase;
        nextPhase <= ~nextPhase;
      end else if (finish) begin
        busyQ <= 1'b0;
      end else if (busyQ) begin
        iterCnt <= iterCnt + 1'b1;
      end
    end
  end

  assign busy     = busyQ;
  assign done     = doneQ;
  assign runPhase = phaseQ;

  // R6
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6
  run_length_chk: assert property (@(posedge clk) disable iff (!rstN)
    busyQ |-> (int'(iterCnt) < NPORT));

  // R9
  start_busy_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busyQ && start) |=> $stable(runPhase));
endmodule

// File: rtl/sm_datapath.sv
module sm_datapath
  import xbar_sched_pkg::*;
#(
  parameter int NPORT = NPORT_DEF,
  parameter int DEPTH = DEPTH_DEF,
  parameter int RANKW = RANKW_DEF
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  schedStrobe_t                                  stb,
  input  logic [NPORT-1:0][DEPTH-1:0][$clog2(NPORT)-1:0] cellDest,
  input  logic [NPORT-1:0][DEPTH-1:0][RANKW-1:0]         cellRank,
  input  logic [NPORT-1:0][DEPTH-1:0]                    cellActive,
  output logic                                          sinkFound,
  output logic                                          lastStep,
  output logic [NPORT-1:0]                               grantValid,
  output logic [NPORT-1:0][$clog2(NPORT)-1:0]            grantOut,
  output logic [NPORT-1:0][$clog2(DEPTH)-1:0]            grantSlot
);
  localparam int OW = $clog2(NPORT);
  localparam int SW = $clog2(DEPTH);

  logic [NPORT-1:0][DEPTH-1:0][OW-1:0]    capDest;
  logic [NPORT-1:0][DEPTH-1:0][RANKW-1:0] capRank;
  logic [NPORT-1:0][DEPTH-1:0]            remQ;
  logic [NPORT-1:0][DEPTH-1:0]            sinkVec;
  logic [NPORT-1:0][DEPTH-1:0]            nextRem;
  logic [OW-1:0]                          selIn;
  logic [SW-1:0]                          selSlot;
  logic [OW-1:0]                          selDest;
  logic [RANKW-1:0]                       selRank;

  // departure order at one output: rank, then input, then slot
  function automatic logic isAhead(input logic [RANKW-1:0] rA, input int iA, input int kA,
                                   input logic [RANKW-1:0] rB, input int iB, input int kB);
    if (rA != rB) return rA < rB;
    if (iA != iB) return iA < iB;
    return kA < kB;
  endfunction

  for (genvar gi = 0; gi < NPORT; gi++) begin : g_in
    for (genvar gk = 0; gk < DEPTH; gk++) begin : g_slot
      logic inBlk;
      logic outBlk;
      always_comb begin
        inBlk = 1'b0;
        for (int j = 0; j < gk; j++) inBlk = inBlk | remQ[gi][j];
        outBlk = 1'b0;
        for (int i2 = 0; i2 < NPORT; i2++) begin
          for (int k2 = 0; k2 < DEPTH; k2++) begin
            if (remQ[i2][k2] && (capDest[i2][k2] == capDest[gi][gk]) &&
                isAhead(capRank[i2][k2], i2, k2, capRank[gi][gk], gi, gk))
              outBlk = 1'b1;
          end
        end
      end
      assign sinkVec[gi][gk] = remQ[gi][gk] & ~inBlk & ~outBlk;

      // R8
      sink_rank_chk: assert property (@(posedge clk) disable iff (!rstN)
        (stb.step && sinkFound && remQ[gi][gk] && (capDest[gi][gk] == selDest))
          |-> (capRank[gi][gk] >= selRank));
    end
  end

  always_comb begin
    selIn   = '0;
    selSlot = '0;
    for (int i = NPORT - 1; i >= 0; i--) begin
      for (int k = DEPTH - 1; k >= 0; k--) begin
        if (sinkVec[i][k]) begin
          selIn   = OW'(i);
          selSlot = SW'(k);
        end
      end
    end
    sinkFound = |sinkVec;
    selDest   = capDest[selIn][selSlot];
    selRank   = capRank[selIn][selSlot];
  end

  always_comb begin
    for (int i = 0; i < NPORT; i++) begin
      for (int k = 0; k < DEPTH; k++) begin
        nextRem[i][k] = remQ[i][k] && (OW'(i) != selIn) && (capDest[i][k] != selDest);
      end
    end
    lastStep = (nextRem == '0);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      capDest    <= '0;
      capRank    <= '0;
      remQ       <= '0;
      grantValid <= '0;
      grantOut   <= '0;
      grantSlot  <= '0;
    end else if (stb.load) begin
      capDest    <= cellDest;
      capRank    <= cellRank;
      remQ       <= cellActive;
      grantValid <= '0;
      grantOut   <= '0;
      grantSlot  <= '0;
    end else if (stb.step && sinkFound) begin
      remQ              <= nextRem;
      grantValid[selIn] <= 1'b1;
      grantOut[selIn]   <= selDest;
      grantSlot[selIn]  <= selSlot;
    end
  end

  for (genvar ga = 0; ga < NPORT; ga++) begin : g_pa
    for (genvar gb = ga + 1; gb < NPORT; gb++) begin : g_pb
      // R1
      out_unique_chk: assert property (@(posedge clk) disable iff (!rstN)
        (grantValid[ga] && grantValid[gb]) |-> (grantOut[ga] != grantOut[gb]));
    end
  end

  // R10
  grant_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!stb.load && !stb.step) |=> ($stable(grantValid) && $stable(grantOut) && $stable(grantSlot)));
endmodule

// File: rtl/stable_match_sched.sv
module stable_match_sched
  import xbar_sched_pkg::*;
#(
  parameter int NPORT = NPORT_DEF,
  parameter int DEPTH = DEPTH_DEF,
  parameter int RANKW = RANKW_DEF
) (
  input  logic                                          clk,
  input  logic                                          rstN,
  input  logic                                          start,
  input  logic [NPORT-1:0][DEPTH-1:0][$clog2(NPORT)-1:0] cellDest,
  input  logic [NPORT-1:0][DEPTH-1:0][RANKW-1:0]         cellRank,
  input  logic [NPORT-1:0][DEPTH-1:0]                    cellActive,
  output logic [NPORT-1:0]                               grantValid,
  output logic [NPORT-1:0][$clog2(NPORT)-1:0]            grantOut,
  output logic [NPORT-1:0][$clog2(DEPTH)-1:0]            grantSlot,
  output logic                                          busy,
  output logic                                          done,
  output logic                                          runPhase
);
  schedStrobe_t stb;
  logic         sinkFound;
  logic         lastStep;

  sm_ctrl #(.NPORT(NPORT)) u_ctrl (
    .clk(clk), .rstN(rstN), .start(start),
    .sinkFound(sinkFound), .lastStep(lastStep),
    .stb(stb), .busy(busy), .done(done), .runPhase(runPhase)
  );

  sm_datapath #(.NPORT(NPORT), .DEPTH(DEPTH), .RANKW(RANKW)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb),
    .cellDest(cellDest), .cellRank(cellRank), .cellActive(cellActive),
    .sinkFound(sinkFound), .lastStep(lastStep),
    .grantValid(grantValid), .grantOut(grantOut), .grantSlot(grantSlot)
  );
endmodule

// File: tb/tb_stable_match_sched.sv
module tb_stable_match_sched;
  localparam int N  = 4;
  localparam int D  = 4;
  localparam int RW = 6;
  localparam int OW = 2;
  localparam int SW = 2;
  localparam int CLK_PERIOD_NS = 10;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic start = 1'b0;
  logic [N-1:0][D-1:0][OW-1:0] cellDest = '0;
  logic [N-1:0][D-1:0][RW-1:0] cellRank = '0;
  logic [N-1:0][D-1:0]         cellActive = '0;
  logic [N-1:0]                grantValid;
  logic [N-1:0][OW-1:0]        grantOut;
  logic [N-1:0][SW-1:0]        grantSlot;
  logic busy, done, runPhase;

  always #(CLK_PERIOD_NS / 2) clk = ~clk;

  stable_match_sched #(.NPORT(N), .DEPTH(D), .RANKW(RW)) dut (
    .clk(clk), .rstN(rstN), .start(start),
    .cellDest(cellDest), .cellRank(cellRank), .cellActive(cellActive),
    .grantValid(grantValid), .grantOut(grantOut), .grantSlot(grantSlot),
    .busy(busy), .done(done), .runPhase(runPhase)
  );

  typedef struct {
    logic [N-1:0]         v;
    logic [N-1:0][OW-1:0] o;
    logic [N-1:0][SW-1:0] s;
    int                   cycles;
    logic                 ph;
    bit                   full;
  } expItem_t;

  expItem_t expQ[$];
  expItem_t lastExp;
  int   checks = 0;
  int   failures = 0;
  int   runLen = 0;
  logic expPh = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  function automatic bit isAheadTb(input int rA, input int iA, input int kA,
                                   input int rB, input int iB, input int kB);
    if (rA != rB) return rA < rB;
    if (iA != iB) return iA < iB;
    return kA < kB;
  endfunction

  function automatic bit isSinkTb(input logic [N-1:0][D-1:0] rem, input int i, input int k);
    for (int j = 0; j < k; j++) if (rem[i][j]) return 0;
    for (int i2 = 0; i2 < N; i2++)
      for (int k2 = 0; k2 < D; k2++)
        if (rem[i2][k2] && cellDest[i2][k2] == cellDest[i][k] &&
            isAheadTb(cellRank[i2][k2], i2, k2, cellRank[i][k], i, k)) return 0;
    return 1;
  endfunction

  task automatic buildModel(output expItem_t e);
    logic [N-1:0][D-1:0] rem;
    int m;
    int fi;
    int fk;
    bit stuck;
    rem = cellActive; m = 0; stuck = 0;
    e.v = '0; e.o = '0; e.s = '0;
    for (int it = 0; it < N && !stuck; it++) begin
      fi = -1; fk = -1;
      for (int i = 0; i < N; i++)
        for (int k = 0; k < D; k++)
          if (fi < 0 && rem[i][k] && isSinkTb(rem, i, k)) begin fi = i; fk = k; end
      if (fi < 0) stuck = 1;
      else begin
        e.v[fi] = 1'b1; e.o[fi] = cellDest[fi][fk]; e.s[fi] = SW'(fk); m++;
        for (int i = 0; i < N; i++)
          for (int k = 0; k < D; k++)
            if (i == fi || cellDest[i][k] == cellDest[fi][fk]) rem[i][k] = 1'b0;
      end
    end
    e.full = (rem == '0);
    e.cycles = (rem != '0) ? m + 1 : ((m == 0) ? 1 : m);
    e.ph = 1'b0;
  endtask

  // monitor: pops expected results as done pulses appear
  always @(negedge clk) begin
    if (rstN) begin
      if (busy) runLen++;
      if (done) begin
        if (expQ.size() == 0) begin
          chk(0, "R9", "unexpected done", 1, 0);
        end else begin
          expItem_t e;
          e = expQ.pop_front();
          chk(grantValid == e.v, "R4", "grantValid", int'(grantValid), int'(e.v));
          for (int i = 0; i < N; i++) begin
            if (e.v[i] && grantValid[i]) begin
              chk(grantOut[i] == e.o[i], "R4", "grantOut", int'(grantOut[i]), int'(e.o[i]));
              chk(grantSlot[i] == e.s[i], "R4", "grantSlot", int'(grantSlot[i]), int'(e.s[i]));
            end
          end
          chk(runLen == e.cycles, "R6", "busy cycles", runLen, e.cycles);
          chk(runPhase == e.ph, "R11", "runPhase", int'(runPhase), int'(e.ph));
        end
        runLen = 0;
      end
    end
  end

  task automatic checkResult();
    bit ok;
    int used;
    // R1: output uniqueness
    for (int a = 0; a < N; a++) begin
      for (int b = a + 1; b < N; b++) begin
        if (grantValid[a] && grantValid[b])
          chk(grantOut[a] != grantOut[b], "R1", "shared output", int'(grantOut[a]), -1);
      end
    end
    // R3: granted slot is active and matches its destination
    for (int i = 0; i < N; i++) begin
      if (grantValid[i]) begin
        chk(cellActive[i][grantSlot[i]] == 1'b1, "R3", "granted inactive slot", 0, 1);
        chk(cellDest[i][grantSlot[i]] == grantOut[i], "R3", "grant dest", int'(grantOut[i]),
            int'(cellDest[i][grantSlot[i]]));
      end
    end
    if (lastExp.full) begin
      // R2: stability of every active cell
      for (int i = 0; i < N; i++) begin
        for (int k = 0; k < D; k++) begin
          if (cellActive[i][k]) begin
            ok = grantValid[i] && (int'(grantSlot[i]) <= k);
            for (int i2 = 0; i2 < N; i2++)
              if (grantValid[i2] && grantOut[i2] == cellDest[i][k] &&
                  isAheadTb(cellRank[i2][grantSlot[i2]], i2, grantSlot[i2], cellRank[i][k], i, k))
                ok = 1;
            chk(ok, "R2", "unstable cell", i * D + k, -1);
          end
        end
      end
    end
    // R5: head of both lists always matched
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < D; k++) begin
        if (cellActive[i][k] && isSinkTb(cellActive, i, k)) begin
          used = (grantValid[i] && int'(grantSlot[i]) == k) ? 1 : 0;
          chk(used == 1, "R5", "double head unmatched", used, 1);
        end
      end
    end
  endtask

  task automatic runCase(input bit disturb);
    expItem_t e;
    @(negedge clk);
    buildModel(e);
    e.ph = expPh;
    expPh = ~expPh;
    expQ.push_back(e);
    lastExp = e;
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(grantValid == '0, "R10", "grants cleared at start", int'(grantValid), 0);
    if (disturb) begin
      cellActive = '0;
      cellRank = '1;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    if (!disturb) checkResult();
  endtask

  task automatic clearLists();
    cellActive = '0;
    cellDest = '0;
    cellRank = '0;
  endtask

  task automatic randLists();
    for (int i = 0; i < N; i++) begin
      for (int k = 0; k < D; k++) begin
        lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
        cellActive[i][k] = (lfsr[2:0] != 3'd0) && (lfsr[2:0] != 3'd1);
        cellDest[i][k]   = lfsr[5:4];
        cellRank[i][k]   = RW'(lfsr[11:8] & 4'h7);
      end
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    chk(0, "R6", "watchdog expired", 0, 1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R12: reset state
    chk(busy == 1'b0 && done == 1'b0, "R12", "busy/done in reset", int'({busy, done}), 0);
    chk(grantValid == '0 && runPhase == 1'b0, "R12", "grants/phase in reset",
        int'({grantValid, runPhase}), 0);
    rstN = 1'b1;
    @(negedge clk);

    // R7: nothing active
    clearLists();
    runCase(0);
    chk(grantValid == '0, "R7", "grants with no active cell", int'(grantValid), 0);

    // diagonal: four simultaneous sinks, lowest input first (R4, R6)
    clearLists();
    for (int i = 0; i < N; i++) begin
      cellActive[i][0] = 1'b1;
      cellDest[i][0] = OW'(i);
      cellRank[i][0] = RW'(3 - i);
    end
    runCase(0);
    chk(grantValid == 4'hF, "R4", "diagonal all granted", int'(grantValid), 15);

    // contention on output 0: lowest rank wins (R8)
    clearLists();
    for (int i = 0; i < N; i++) cellActive[i][0] = 1'b1;
    cellRank[0][0] = 6'd5; cellRank[1][0] = 6'd3; cellRank[2][0] = 6'd7; cellRank[3][0] = 6'd1;
    runCase(0);
    chk(grantValid == 4'b1000, "R8", "lowest rank wins", int'(grantValid), 8);

    // equal ranks: lower input wins (R8)
    clearLists();
    for (int i = 0; i < N; i++) begin
      cellActive[i][0] = 1'b1;
      cellDest[i][0] = 2'd2;
      cellRank[i][0] = 6'd4;
    end
    runCase(0);
    chk(grantValid == 4'b0001, "R8", "tie to lower input", int'(grantValid), 1);

    // inactive head ignored (R3)
    clearLists();
    cellDest[0][0] = 2'd1; cellRank[0][0] = 6'd0;
    cellActive[0][1] = 1'b1; cellDest[0][1] = 2'd1; cellRank[0][1] = 6'd2;
    cellActive[1][0] = 1'b1; cellDest[1][0] = 2'd1; cellRank[1][0] = 6'd5;
    runCase(0);
    chk(grantValid[0] && grantSlot[0] == 2'd1, "R3", "slot behind inactive head",
        int'(grantSlot[0]), 1);

    // dependency cycle with no sink (R13)
    clearLists();
    cellActive[0][0] = 1'b1; cellDest[0][0] = 2'd0; cellRank[0][0] = 6'd5;
    cellActive[0][1] = 1'b1; cellDest[0][1] = 2'd1; cellRank[0][1] = 6'd1;
    cellActive[1][0] = 1'b1; cellDest[1][0] = 2'd1; cellRank[1][0] = 6'd5;
    cellActive[1][1] = 1'b1; cellDest[1][1] = 2'd0; cellRank[1][1] = 6'd1;
    runCase(0);
    chk(grantValid == '0, "R13", "cycle leaves all unmatched", int'(grantValid), 0);

    // inputs and start changed during a run (R9), then hold (R10)
    clearLists();
    for (int i = 0; i < N; i++) begin
      cellActive[i][0] = 1'b1;
      cellDest[i][0] = OW'(3 - i);
    end
    runCase(1);
    repeat (3) @(negedge clk);
    chk(busy == 1'b0 && done == 1'b0, "R9", "start during run ignored", int'({busy, done}), 0);
    chk(grantValid == lastExp.v, "R10", "grants held after done", int'(grantValid), int'(lastExp.v));
    chk(expQ.size() == 0, "R9", "pending results", expQ.size(), 0);

    // pseudo-random lists with rank collisions
    for (int n = 0; n < 40; n++) begin
      randLists();
      runCase(0);
    end

    repeat (3) @(negedge clk);
    chk(expQ.size() == 0, "R6", "results outstanding", expQ.size(), 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule